// File: doc/BRIEF.md
# Delayed Branch Fetch Sequencer

This block holds the program counter pair of an in-order pipeline that has one branch delay slot. It keeps the address of the instruction being handled (`pc_o`) and the address that follows it (`npc_o`). A control transfer never redirects the instruction right after the branch. It only rewrites the following address, so the slot instruction always flows next. The slot instruction is then either committed or reduced to a no-op. Nothing is fetched speculatively and nothing is rolled back.

Each time `step_i` is high, the decoded fields of the instruction at `pc_o` are applied. For a conditional branch, the 4-bit condition is evaluated against integer flags that earlier compare or arithmetic operations produced. The sequencer then decides whether the branch is taken and whether the slot instruction is annulled. The annul decision uses both the branch's annul bit and the branch outcome. It is presented on `annul_o` while that slot instruction sits at `pc_o`. A single redirect input overrides the sequence, for example on a trap entry.

Top module: `branch_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `pc_o` equals `RESET_PC`, `npc_o` equals `RESET_PC+4` and `annul_o` is 0.
- R2: On a clock edge with `step_i` high and no redirect, `pc_o` takes the old `npc_o`. When no transfer is taken, `npc_o` advances by 4. With `step_i` low and no redirect, all outputs hold.
- R3: Flags are `icc_i = {N,Z,V,C}` (bit 3 is N). Conditions 0 to 7 are: never, Z, Z|(N^V), N^V, C|Z, C, N, V. Conditions 8 to 15 are the complements of 0 to 7 in the same order: always, !Z, greater, greater-or-equal, unsigned greater, !C, !N, !V.
- R4: `br_type_i` is 2'b01 for a conditional branch. A taken branch loads `target_i` into `npc_o`, so the target is handled only after the slot instruction.
- R5: With `annul_bit_i` = 0, a conditional branch never annuls its slot (`annul_o` is 0 on the next instruction).
- R6: With `annul_bit_i` = 1, a conditional branch whose condition is neither 0 nor 8 lets the slot execute when taken and annuls it when not taken.
- R7: With `annul_bit_i` = 1, condition 8 (always) annuls the slot and still sends the flow to `target_i`. Condition 0 (never) annuls the slot and continues sequentially.
- R8: An instruction stepped while `annul_o` = 1 is a no-op. Its branch fields are ignored, `npc_o` advances by 4, and the next instruction is not annulled.
- R9: A taken branch that sits in the slot of a taken branch sends one instruction to the first target and then continues at its own target.
- R10: `br_type_i` = 2'b10 is an unconditional jump. It is always taken to `target_i`, its annul bit is ignored, and its slot executes. Codes 2'b00 and 2'b11 are not transfers.
- R11: `redirect_i` overrides `step_i`. The next `pc_o` is `redirect_pc_i`, `npc_o` is `redirect_pc_i+4`, and `annul_o` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Apply the instruction at `pc_o` and advance |
| redirect_i | input | 1 | Override the flow |
| redirect_pc_i | input | ADDR_W | Address used on a redirect |
| br_type_i | input | 2 | 00 none, 01 conditional branch, 10 jump, 11 none |
| cond_i | input | 4 | Branch condition code |
| annul_bit_i | input | 1 | Annul bit of the branch |
| target_i | input | ADDR_W | Branch or jump destination |
| icc_i | input | 4 | Integer flags {N,Z,V,C} |
| pc_o | output | ADDR_W | Address of the current instruction |
| npc_o | output | ADDR_W | Address of the following instruction |
| annul_o | output | 1 | The instruction at `pc_o` is annulled |

## Verification
Every one of the 16 conditions is driven with several flag patterns. The next address is then either the target or the sequential address, which isolates each flag term and its complement. The annul bit is crossed with taken and not-taken outcomes and with the always and never codes, which separates the four slot outcomes. Back-to-back branches, branches sitting in annulled slots, jumps with the annul bit set, and redirects taken in the same cycle as a step each expose a different priority path. A long random mix with a fixed seed covers everything else against a bench model.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  typedef enum logic [1:0] {
    BT_NONE = 2'b00,
    BT_COND = 2'b01,
    BT_JUMP = 2'b10,
    BT_RSVD = 2'b11
  } br_type_e;

  localparam logic [3:0] COND_NEVER  = 4'h0;
  localparam logic [3:0] COND_ALWAYS = 4'h8;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] icc_i,
  output logic       pass_o
);
  logic n, z, v, c;
  logic [7:0] base;

  assign {n, z, v, c} = icc_i;

  // lower half; upper half is the complement
  assign base[0] = 1'b0;
  assign base[1] = z;
  assign base[2] = z | (n ^ v);
  assign base[3] = n ^ v;
  assign base[4] = c | z;
  assign base[5] = c;
  assign base[6] = n;
  assign base[7] = v;

  assign pass_o = base[cond_i[2:0]] ^ cond_i[3];
endmodule

// File: rtl/branch_slot_ctrl.sv
module branch_slot_ctrl
  import branch_seq_pkg::*;
(
  input  br_type_e   br_type_i,
  input  logic [3:0] cond_i,
  input  logic       annul_bit_i,
  input  logic       pass_i,
  input  logic       cur_annulled_i,
  output logic       taken_o,
  output logic       annul_next_o
);
  logic live_cond, live_jump;

  assign live_cond = !cur_annulled_i && (br_type_i == BT_COND);
  assign live_jump = !cur_annulled_i && (br_type_i == BT_JUMP);

  assign taken_o = (live_cond && pass_i) || live_jump;

  // annul on not-taken, or on branch-always
  assign annul_next_o = live_cond && annul_bit_i &&
                        (!pass_i || (cond_i == COND_ALWAYS));
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_pc_i,
  input  logic [1:0]        br_type_i,
  input  logic [3:0]        cond_i,
  input  logic              annul_bit_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [3:0]        icc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic              annul_o
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] pc_q, npc_q;
  logic              annul_q;
  logic              pass, taken, annul_nxt;
  br_type_e          br_type;

  assign br_type = br_type_e'(br_type_i);

  branch_cond_eval u_cond (
    .cond_i (cond_i),
    .icc_i  (icc_i),
    .pass_o (pass)
  );

  branch_slot_ctrl u_slot (
    .br_type_i      (br_type),
    .cond_i         (cond_i),
    .annul_bit_i    (annul_bit_i),
    .pass_i         (pass),
    .cur_annulled_i (annul_q),
    .taken_o        (taken),
    .annul_next_o   (annul_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      npc_q   <= RESET_PC + INC;
      annul_q <= 1'b0;
    end else if (redirect_i) begin
      pc_q    <= redirect_pc_i;
      npc_q   <= redirect_pc_i + INC;
      annul_q <= 1'b0;
    end else if (step_i) begin
      pc_q    <= npc_q;
      npc_q   <= taken ? target_i : npc_q + INC;
      annul_q <= annul_nxt;
    end
  end

  assign pc_o    = pc_q;
  assign npc_o   = npc_q;
  assign annul_o = annul_q;
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned INSTR_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic              redirect_i,
  input logic [ADDR_W-1:0] redirect_pc_i,
  input logic [1:0]        br_type_i,
  input logic [3:0]        cond_i,
  input logic              annul_bit_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] npc_o,
  input logic              annul_o
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(INSTR_BYTES);

  logic adv;
  assign adv = step_i && !redirect_i;

  // R2
  pc_follows_npc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> pc_o == $past(npc_o));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !redirect_i) |=> ($stable(pc_o) && $stable(npc_o) && $stable(annul_o)));

  // R8
  annulled_is_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && annul_o) |=> (!annul_o && npc_o == $past(npc_o) + INC));

  // R5
  clear_bit_runs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !annul_bit_i) |=> !annul_o);

  // R10
  jump_slot_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !annul_o && br_type_i == 2'b10) |=> (!annul_o && npc_o == $past(target_i)));

  // R7
  always_annul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !annul_o && br_type_i == 2'b01 && cond_i == 4'h8 && annul_bit_i)
      |=> (annul_o && npc_o == $past(target_i)));

  // R11
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (pc_o == $past(redirect_pc_i) && npc_o == $past(redirect_pc_i) + INC && !annul_o));
endmodule

bind branch_seq branch_seq_chk #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .step_i        (step_i),
  .redirect_i    (redirect_i),
  .redirect_pc_i (redirect_pc_i),
  .br_type_i     (br_type_i),
  .cond_i        (cond_i),
  .annul_bit_i   (annul_bit_i),
  .target_i      (target_i),
  .pc_o          (pc_o),
  .npc_o         (npc_o),
  .annul_o       (annul_o)
);

// File: tb/tb_branch_seq.sv
module tb_branch_seq;
  localparam int AW = 32;
  localparam logic [AW-1:0] RST_PC = 32'h0000_1000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          step_i = 1'b0, redirect_i = 1'b0, annul_bit_i = 1'b0;
  logic [AW-1:0] redirect_pc_i = '0, target_i = '0;
  logic [1:0]    br_type_i = 2'b00;
  logic [3:0]    cond_i = 4'h0, icc_i = 4'h0;
  logic [AW-1:0] pc_o, npc_o;
  logic          annul_o;

  int errors = 0, checks = 0;
  logic [AW-1:0] m_pc, m_npc;
  logic          m_an;

  always #2.5 clk_i = ~clk_i;

  branch_seq #(.ADDR_W(AW), .RESET_PC(RST_PC)) dut (.*);

  function automatic logic f_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cc, r;
    {n, z, v, cc} = f;
    case (c[2:0])
      3'd0: r = 1'b0;
      3'd1: r = z;
      3'd2: r = z | (n ^ v);
      3'd3: r = n ^ v;
      3'd4: r = cc | z;
      3'd5: r = cc;
      3'd6: r = n;
      default: r = v;
    endcase
    return r ^ c[3];
  endfunction

  task automatic check(input string tag);
    checks++;
    if (pc_o !== m_pc || npc_o !== m_npc || annul_o !== m_an) begin
      errors++;
      $display("FAIL %s: pc=%h npc=%h an=%b expected pc=%h npc=%h an=%b",
               tag, pc_o, npc_o, annul_o, m_pc, m_npc, m_an);
    end
  endtask

  task automatic cyc(input logic rd, input logic [AW-1:0] rpc, input logic st,
                     input logic [1:0] ty, input logic [3:0] cd, input logic a,
                     input logic [AW-1:0] tg, input logic [3:0] f, input string tag);
    logic tk, an_n, ok;
    redirect_i = rd; redirect_pc_i = rpc; step_i = st; br_type_i = ty;
    cond_i = cd; annul_bit_i = a; target_i = tg; icc_i = f;
    ok = f_pass(cd, f);
    if (rd) begin
      m_pc = rpc; m_npc = rpc + 4; m_an = 1'b0;
    end else if (st) begin
      tk   = !m_an && ((ty == 2'b01 && ok) || ty == 2'b10);
      an_n = !m_an && ty == 2'b01 && a && (!ok || cd == 4'h8);
      m_pc = m_npc;
      m_npc = tk ? tg : m_npc + 4;
      m_an = an_n;
    end
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic br(input logic [3:0] cd, input logic a, input logic [AW-1:0] tg,
                    input logic [3:0] f, input string tag);
    cyc(1'b0, '0, 1'b1, 2'b01, cd, a, tg, f, tag);
  endtask

  task automatic seq(input string tag);
    cyc(1'b0, '0, 1'b1, 2'b00, 4'h0, 1'b0, '0, 4'h0, tag);
  endtask

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_pc = RST_PC; m_npc = RST_PC + 4; m_an = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");

    seq("R2 sequential");
    cyc(1'b0, '0, 1'b0, 2'b01, 4'h8, 1'b1, 32'h40, 4'h0, "R2 idle hold");

    // R3: every condition with several flag patterns, annul bit clear
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f += 3) begin
        br(4'(c), 1'b0, 32'h2000 + 32'(c * 64), 4'(f), "R3 condition");
        seq("R3 slot");
      end

    // R4 taken, target after slot
    br(4'h1, 1'b0, 32'h3000, 4'b0100, "R4 taken");
    seq("R4 target reached");
    // R5 annul clear, not taken
    br(4'h1, 1'b0, 32'h3100, 4'b0000, "R5 no annul");
    seq("R5 slot");
    // R6
    br(4'h1, 1'b1, 32'h3200, 4'b0100, "R6 taken keeps slot");
    seq("R6 slot");
    br(4'h1, 1'b1, 32'h3300, 4'b0000, "R6 untaken annuls");
    seq("R6 annulled slot");
    // R7
    br(4'h8, 1'b1, 32'h3400, 4'h0, "R7 always annuls");
    seq("R7 target");
    br(4'h0, 1'b1, 32'h3500, 4'h0, "R7 never annuls");
    seq("R7 sequential");
    // R8: branch in annulled slot ignored
    br(4'h0, 1'b1, 32'h3600, 4'h0, "R8 setup");
    br(4'h8, 1'b1, 32'h3700, 4'h0, "R8 ignored branch");
    seq("R8 after");
    // R9 branch couple
    br(4'h8, 1'b0, 32'h4000, 4'h0, "R9 first");
    br(4'h8, 1'b0, 32'h5000, 4'h0, "R9 second");
    seq("R9 first target");
    seq("R9 second target");
    // R10 jump with annul bit set
    cyc(1'b0, '0, 1'b1, 2'b10, 4'h0, 1'b1, 32'h6000, 4'h0, "R10 jump");
    seq("R10 slot");
    cyc(1'b0, '0, 1'b1, 2'b11, 4'h8, 1'b1, 32'h6100, 4'h0, "R10 reserved");
    // R11 redirect beats step
    br(4'h0, 1'b1, 32'h6200, 4'h0, "R11 setup");
    cyc(1'b1, 32'h7000, 1'b1, 2'b01, 4'h8, 1'b1, 32'h7100, 4'h0, "R11 redirect");

    for (int i = 0; i < 3000; i++) begin
      logic rd, st, a;
      logic [1:0] ty;
      logic [3:0] cd;
      string tag;
      rd = ($urandom % 20) == 0;
      st = ($urandom % 8) != 0;
      ty = 2'($urandom);
      cd = 4'($urandom);
      a  = 1'($urandom);
      if (rd) tag = "R11 random";
      else if (!st) tag = "R2 random idle";
      else if (m_an) tag = "R8 random";
      else if (ty == 2'b10) tag = "R10 random";
      else if (ty != 2'b01) tag = "R2 random";
      else if (!a) tag = "R5 random";
      else if (cd[2:0] == 3'd0) tag = "R7 random";
      else tag = "R6 random";
      cyc(rd, {$urandom, 2'b00} >> 2 << 2, st, ty, cd, a,
          32'($urandom) & ~32'h3, 4'($urandom), tag);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule